// File: doc/BRIEF.md
# Multi-Channel 16-Bit PWM Timer Bank

This block holds a parameterised set of independent PWM timer channels (five, six or eight in the supported builds). Each channel has a 16-bit up-counter, a duty compare value, a period compare value and a three-bit control word. Software reaches all of them over a simple single-cycle register bus. The output pin of a channel rests at a programmable level and flips to the opposite level after the counter passes the duty value. It returns to the rest level when the counter wraps at the period value. To invert the polarity of the waveform, software flips the rest level.

Two shared strobe addresses start and stop the counters, one bit per channel. Writing a one to the set address starts a counter. Writing a one to the clear address stops it. Reading either address returns the per-channel running status. A stopped counter keeps its value. Software may write the counter directly, which also restarts the waveform phase.

Each channel contains a three-state output machine. In **CH_IDLE** the pin drives the rest level. In **CH_DRIVE** the pin follows the compare logic. In **CH_DRAIN** output enable has been removed without the abrupt-shutdown bit, and the pin holds the level it had until the period ends. The transitions are as follows:
- *enable* (CH_IDLE to CH_DRIVE): output enable is set.
- *cut* (CH_DRIVE to CH_IDLE): output enable is cleared while abrupt is set.
- *soften* (CH_DRIVE to CH_DRAIN): output enable is cleared while abrupt is clear.
- *release* (CH_DRAIN to CH_IDLE): on the counter wrap, on a stopped counter, or when abrupt is set.
- *resume* (CH_DRAIN to CH_DRIVE): output enable is set again.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every pin is low, every counter is stopped, and the status, control, duty, period and count registers all read 0.
- R2: While it runs, a counter goes up by one each clock. In the cycle where it equals the period value it steps to 0 instead, so one full cycle lasts period+1 clocks.
- R3: The pin leaves the rest level in the clock after the counter equals the duty value. It returns to the rest level in the clock after the counter equals the period value. With the counter reading c, the pin is active exactly when duty < c <= period.
- R4: Address 0x40 is the start strobe and address 0x41 is the stop strobe. Data bit n acts on channel n, and zero bits change nothing. Reading either address returns the running status, with bit n set for each running channel n.
- R5: Control bit 1 selects the rest level (1 means high). The active level is its inverse.
- R6: Control bit 0 is output enable. When it is cleared while control bit 2 (abrupt) is set, the pin shows the rest level from the clock after the control register changes.
- R7: When output enable is cleared with abrupt clear, the pin holds its current level until the counter wraps at the period value. From then on it shows the rest level and no longer follows the compare.
- R8: When the duty value is equal to or greater than the period value, the pin never leaves the rest level.
- R9: The count register can be written. A stopped counter keeps its value.
- R10: Channel n's registers sit at address 4n plus an offset: 0 for control, 1 for duty, 2 for period, 3 for count. Addresses of channels at or above the NUM_CH parameter, and unused addresses, read 0.
- R11: Channels run independently. Starting, stopping or configuring one channel does not disturb another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every counter tick is one clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register address (channel region below 0x40, strobes at 0x40/0x41) |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | One PWM pin per channel |

## Verification
The hardest case to reach is the graceful shutdown. Output enable has to be removed while the pin is in its active phase and well before the period end, and the pin then has to be seen holding through to the exact wrap clock. The stimulus polls the count register until it reads a chosen value inside the active window and then clears the control word. It keeps reading the count until it reads the period value, and checks the pin there and in the clock after the wrap. The abrupt case uses the same polling approach, so the pin can be shown dropping in the middle of the active window.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // Control word: bit 0 output enable, bit 1 rest level high, bit 2 abrupt
    typedef struct packed {
        logic abrupt;
        logic init_high;
        logic out_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DRIVE = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    // Register offsets inside a channel's four-word window
    localparam logic [1:0] OFS_CTRL   = 2'd0;
    localparam logic [1:0] OFS_DUTY   = 2'd1;
    localparam logic [1:0] OFS_PERIOD = 2'd2;
    localparam logic [1:0] OFS_COUNT  = 2'd3;

endpackage

// File: rtl/pwm_run_ctrl.sv
module pwm_run_ctrl #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic              clr_stb,
    input  logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] run_o
);

    logic [NUM_CH-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (set_stb) begin
            run_q <= run_q | mask;
        end else if (clr_stb) begin
            run_q <= run_q & ~mask;
        end
    end

    assign run_o = run_q;

endmodule

// File: rtl/pwm_out_fsm.sv
module pwm_out_fsm
    import pwm_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic out_en,
    input  logic abrupt,
    input  logic run,
    input  logic wrap,
    input  logic live_level,
    input  logic rest_level,
    output logic pin_o
);

    ch_state_e state_q;
    ch_state_e state_d;
    logic      held_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Level captured while driving, frozen while draining
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (state_q != CH_DRAIN) begin
            held_q <= live_level;
        end
    end

    // Transitions: enable, cut, soften, release, resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (out_en) state_d = CH_DRIVE;
            end
            CH_DRIVE: begin
                if (!out_en) state_d = abrupt ? CH_IDLE : CH_DRAIN;
            end
            CH_DRAIN: begin
                if (out_en)                       state_d = CH_DRIVE;
                else if (abrupt || wrap || !run)  state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        unique case (state_q)
            CH_DRIVE: pin_o = live_level;
            CH_DRAIN: pin_o = held_q;
            default:  pin_o = rest_level;
        endcase
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ctrl_we,
    input  logic             duty_we,
    input  logic             period_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl_o,
    output logic [CNT_W-1:0] duty_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pin_o
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] duty_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;
    logic             flip_q;
    logic             at_period;
    logic             at_duty;
    logic             wrap;

    assign at_period = (cnt_q == period_q);
    assign at_duty   = (cnt_q == duty_q);
    assign wrap      = run && at_period && !cnt_we;

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            duty_q   <= '0;
            period_q <= '0;
        end else begin
            if (ctrl_we)   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (duty_we)   duty_q   <= wdata;
            if (period_we) period_q <= wdata;
        end
    end

    // Counter and compare phase; the period match wins over the duty match
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flip_q <= 1'b0;
        end else if (cnt_we) begin
            cnt_q  <= wdata;
            flip_q <= 1'b0;
        end else if (run) begin
            if (at_period) begin
                cnt_q  <= '0;
                flip_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (at_duty) flip_q <= 1'b1;
            end
        end
    end

    pwm_out_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_en     (ctrl_q.out_en),
        .abrupt     (ctrl_q.abrupt),
        .run        (run),
        .wrap       (wrap),
        .live_level (ctrl_q.init_high ^ flip_q),
        .rest_level (ctrl_q.init_high),
        .pin_o      (pin_o)
    );

    assign ctrl_o   = ctrl_q;
    assign duty_o   = duty_q;
    assign period_o = period_q;
    assign cnt_o    = cnt_q;

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int                CH_SEL_W = ADDR_W - 3;
    localparam logic [ADDR_W-1:0] SET_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] CLR_ADDR = SET_ADDR + 1'b1;

    logic                  is_chan;
    logic [CH_SEL_W-1:0]   ch_idx;
    logic [1:0]            reg_sel;
    logic                  set_stb;
    logic                  clr_stb;
    logic [NUM_CH-1:0]     run_q;

    ctrl_t [NUM_CH-1:0]              ctrl_q;
    logic  [NUM_CH-1:0][CNT_W-1:0]   duty_q;
    logic  [NUM_CH-1:0][CNT_W-1:0]   period_q;
    logic  [NUM_CH-1:0][CNT_W-1:0]   cnt_q;
    logic  [NUM_CH-1:0]              cnt_we_v;
    logic  [NUM_CH-1:0]              ctrl_we_v;
    logic  [NUM_CH-1:0]              en_v;
    logic  [NUM_CH-1:0]              abrupt_v;
    logic  [NUM_CH-1:0]              init_v;

    assign is_chan = !bus_addr[ADDR_W-1];
    assign ch_idx  = bus_addr[ADDR_W-2:2];
    assign reg_sel = bus_addr[1:0];
    assign set_stb = bus_wr && (bus_addr == SET_ADDR);
    assign clr_stb = bus_wr && (bus_addr == CLR_ADDR);

    pwm_run_ctrl #(.NUM_CH(NUM_CH)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .mask    (bus_wdata[NUM_CH-1:0]),
        .run_o   (run_q)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic hit;
        assign hit          = bus_wr && is_chan && (ch_idx == CH_SEL_W'(n));
        assign cnt_we_v[n]  = hit && (reg_sel == OFS_COUNT);
        assign ctrl_we_v[n] = hit && (reg_sel == OFS_CTRL);

        pwm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_q[n]),
            .ctrl_we   (ctrl_we_v[n]),
            .duty_we   (hit && (reg_sel == OFS_DUTY)),
            .period_we (hit && (reg_sel == OFS_PERIOD)),
            .cnt_we    (cnt_we_v[n]),
            .wdata     (bus_wdata),
            .ctrl_o    (ctrl_q[n]),
            .duty_o    (duty_q[n]),
            .period_o  (period_q[n]),
            .cnt_o     (cnt_q[n]),
            .pin_o     (pwm_out[n])
        );

        assign en_v[n]     = ctrl_q[n].out_en;
        assign abrupt_v[n] = ctrl_q[n].abrupt;
        assign init_v[n]   = ctrl_q[n].init_high;
    end

    // Read path
    always_comb begin
        bus_rdata = '0;
        if (is_chan) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (ch_idx == CH_SEL_W'(n)) begin
                    case (reg_sel)
                        OFS_CTRL:   bus_rdata = CNT_W'(ctrl_q[n]);
                        OFS_DUTY:   bus_rdata = duty_q[n];
                        OFS_PERIOD: bus_rdata = period_q[n];
                        default:    bus_rdata = cnt_q[n];
                    endcase
                end
            end
        end else if ((bus_addr == SET_ADDR) || (bus_addr == CLR_ADDR)) begin
            bus_rdata = CNT_W'(run_q);
        end
    end

endmodule

// File: rtl/pwm_timer_checker.sv
module pwm_timer_checker #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 7
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_wr,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [NUM_CH-1:0]               mask,
    input logic [NUM_CH-1:0]               run,
    input logic [NUM_CH-1:0][CNT_W-1:0]    cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0]    period,
    input logic [NUM_CH-1:0]               cnt_we,
    input logic [NUM_CH-1:0]               ctrl_we,
    input logic [NUM_CH-1:0]               en,
    input logic [NUM_CH-1:0]               abrupt,
    input logic [NUM_CH-1:0]               init,
    input logic [NUM_CH-1:0]               pwm_out
);

    localparam logic [ADDR_W-1:0] SET_A = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] CLR_A = SET_A + 1'b1;

    logic set_hit;
    logic clr_hit;
    assign set_hit = bus_wr && (bus_addr == SET_A);
    assign clr_hit = bus_wr && (bus_addr == CLR_A);

    AST_SET_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> ((run & $past(mask)) == $past(mask)));               // R4
    AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> ((run & $past(mask)) == '0));                        // R4
    AST_RUN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_hit || clr_hit) |=> $stable(run));                         // R4

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (run[n] && (cnt[n] == period[n]) && !cnt_we[n]) |=> (cnt[n] == '0)); // R2
        AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[n] && !cnt_we[n]) |=> $stable(cnt[n]));                 // R9
        AST_ABRUPT_REST: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[n] && abrupt[n] && !ctrl_we[n]) |=> (pwm_out[n] == init[n])); // R6
    end

endmodule

bind pwm_timer_bank pwm_timer_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .mask     (bus_wdata[NUM_CH-1:0]),
    .run      (run_q),
    .cnt      (cnt_q),
    .period   (period_q),
    .cnt_we   (cnt_we_v),
    .ctrl_we  (ctrl_we_v),
    .en       (en_v),
    .abrupt   (abrupt_v),
    .init     (init_v),
    .pwm_out  (pwm_out)
);

// File: tb/test_pwm_timer_bank.sv
`timescale 1ns/1ps
module test_pwm_timer_bank;

    localparam int NUM_CH = 8;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 7;
    localparam logic [6:0] A_SET = 7'h40;
    localparam logic [6:0] A_CLR = 7'h41;

    // {channel[52:49], rest_high[48], duty[47:32], period[31:16], active clocks over two cycles[15:0]}
    localparam int NV = 7;
    localparam logic [52:0] VEC [NV] = '{
        {4'd2, 1'b0, 16'd3,  16'd7,  16'd8},   // R3 plain duty inside period
        {4'd7, 1'b1, 16'd0,  16'd4,  16'd8},   // R5 rest high, R10 top channel
        {4'd0, 1'b0, 16'd9,  16'd9,  16'd0},   // R8 duty equals period
        {4'd5, 1'b1, 16'd12, 16'd6,  16'd0},   // R8 duty above period
        {4'd3, 1'b0, 16'd1,  16'd2,  16'd2},   // R2 short period
        {4'd1, 1'b1, 16'd0,  16'd0,  16'd0},   // R2 zero period
        {4'd4, 1'b0, 16'd2,  16'd30, 16'd56}   // R3 long period
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_timer_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_pwm_timer_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [6:0] ca(input int ch, input int ofs);
        return 7'(ch * 4 + ofs);
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] a;
        logic [15:0] prev;
        int ch, dv, pv, ev, act;
        bit rest;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pwm_out == '0, "R1 pins after reset", int'(pwm_out), 0);
        rd(A_SET, d);        check(d == 0, "R1 status after reset", d, 0);
        rd(ca(3, 0), d);     check(d == 0, "R1 control after reset", d, 0);
        rd(ca(6, 2), d);     check(d == 0, "R1 period after reset", d, 0);

        // R4 strobes, R9 hold and write, R11 independence
        wr(ca(2, 2), 16'd100);
        wr(A_SET, 16'h0005);
        rd(A_SET, d);        check(d == 16'h5, "R4 set bits 0 and 2", d, 5);
        wr(A_SET, 16'h0000);
        rd(A_SET, d);        check(d == 16'h5, "R4 zero set ignored", d, 5);
        wr(A_CLR, 16'h0000);
        rd(A_CLR, d);        check(d == 16'h5, "R4 zero clear ignored", d, 5);
        wr(A_CLR, 16'h0001);
        rd(A_CLR, d);        check(d == 16'h4, "R4 clear bit 0", d, 4);
        wr(ca(0, 3), 16'h1234);
        rd(ca(0, 3), d);     check(d == 16'h1234, "R9 count write", d, 16'h1234);
        repeat (5) @(negedge clk);
        rd(ca(0, 3), d);     check(d == 16'h1234, "R9 stopped count holds", d, 16'h1234);
        rd(ca(2, 3), a);
        repeat (5) @(negedge clk);
        rd(ca(2, 3), d);     check(d == a + 16'd5, "R11 running neighbour counts", d, a + 5);
        wr(A_CLR, 16'h00FF);
        rd(A_SET, d);        check(d == 0, "R4 all stopped", d, 0);

        // R10 address map
        wr(ca(7, 1), 16'hBEEF);
        rd(ca(7, 1), d);     check(d == 16'hBEEF, "R10 top channel duty", d, 16'hBEEF);
        wr(ca(9, 1), 16'h1111);
        rd(ca(9, 1), d);     check(d == 0, "R10 absent channel reads 0", d, 0);
        rd(7'h42, d);        check(d == 0, "R10 unused address reads 0", d, 0);
        wr(ca(7, 0), 16'hFFFF);
        rd(ca(7, 0), d);     check(d == 16'h7, "R10 control is three bits", d, 7);

        // Vector table: R2 R3 R5 R8
        for (int i = 0; i < NV; i++) begin
            ch   = int'(VEC[i][52:49]);
            rest = VEC[i][48];
            dv   = int'(VEC[i][47:32]);
            pv   = int'(VEC[i][31:16]);
            ev   = int'(VEC[i][15:0]);
            wr(ca(ch, 1), 16'(dv));
            wr(ca(ch, 2), 16'(pv));
            wr(ca(ch, 0), {13'd0, 1'b1, rest, 1'b1});
            wr(ca(ch, 3), 16'd0);
            wr(A_SET, 16'(1 << ch));
            repeat (3) @(negedge clk);
            act = 0;
            for (int k = 0; k < 2 * (pv + 1); k++) begin
                @(negedge clk);
                #1;
                if (pwm_out[ch] != rest) act++;
            end
            check(act == ev, $sformatf("R3 R5 R8 vector %0d active clocks", i), act, ev);
            wr(A_CLR, 16'(1 << ch));
            wr(ca(ch, 0), 16'h0004);
            @(negedge clk);
            check(pwm_out[ch] == 1'b0, $sformatf("R6 vector %0d pin at rest", i), int'(pwm_out[ch]), 0);
        end

        // R3 / R2 cycle-exact waveform on channel 4: duty 3, period 7
        wr(ca(4, 1), 16'd3);
        wr(ca(4, 2), 16'd7);
        wr(ca(4, 0), 16'h0005);
        wr(ca(4, 3), 16'd0);
        wr(A_SET, 16'h0010);
        rd(ca(4, 3), prev);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            rd(ca(4, 3), d);
            check(d == ((prev == 16'd7) ? 16'd0 : prev + 16'd1), "R2 count step", d,
                  (prev == 16'd7) ? 0 : prev + 1);
            check(pwm_out[4] == ((d > 16'd3) && (d <= 16'd7)), "R3 pin against count",
                  int'(pwm_out[4]), int'((d > 16'd3) && (d <= 16'd7)));
            prev = d;
        end
        wr(A_CLR, 16'h0010);

        // R7 graceful shutdown on channel 6: duty 5, period 40
        wr(ca(6, 1), 16'd5);
        wr(ca(6, 2), 16'd40);
        wr(ca(6, 0), 16'h0001);
        wr(ca(6, 3), 16'd0);
        wr(A_SET, 16'h0040);
        d = 0;
        for (int k = 0; k < 200 && d != 16'd10; k++) begin
            @(negedge clk);
            rd(ca(6, 3), d);
        end
        wr(ca(6, 0), 16'h0000);
        rd(ca(6, 3), d);
        check(pwm_out[6] == 1'b1, "R7 level held after disable", int'(pwm_out[6]), 1);
        for (int k = 0; k < 200 && d != 16'd40; k++) begin
            @(negedge clk);
            rd(ca(6, 3), d);
        end
        check(pwm_out[6] == 1'b1, "R7 level held at period end", int'(pwm_out[6]), 1);
        @(negedge clk);
        rd(ca(6, 3), d);
        check((d == 0) && (pwm_out[6] == 1'b0), "R7 rest after wrap", int'(pwm_out[6]), 0);
        repeat (15) @(negedge clk);
        #1;
        check(pwm_out[6] == 1'b0, "R7 compare ignored after release", int'(pwm_out[6]), 0);

        // R6 abrupt shutdown on channel 6
        wr(ca(6, 0), 16'h0005);
        wr(ca(6, 3), 16'd0);
        d = 0;
        for (int k = 0; k < 200 && d != 16'd10; k++) begin
            @(negedge clk);
            rd(ca(6, 3), d);
        end
        check(pwm_out[6] == 1'b1, "R6 active before cut", int'(pwm_out[6]), 1);
        wr(ca(6, 0), 16'h0004);
        @(negedge clk);
        #1;
        check(pwm_out[6] == 1'b0, "R6 rest right after cut", int'(pwm_out[6]), 0);
        rd(ca(6, 3), d);
        check(d > 16'd10 && d < 16'd40, "R6 counter keeps running", d, 14);
        wr(A_CLR, 16'h0040);

        done = 1'b1;
        finish_run();
    end

endmodule